// File: doc/BRIEF.md
# Physical-to-ECC address generator

This block turns a physical data address into the byte address of that data's strong (tier-2) error-correction code in memory. The tier-2 codes are kept in ordinary memory. A three-level translation table, also in memory, maps each physical data page to an ECC page and sets the protection strength for that page. The block walks this table one level at a time over a memory read port. It starts from a table base pointer. The page offset is then compressed by the per-page code size, so that the codes of consecutive 64-byte data lines pack tightly into one 64-byte code line.

A request is accepted when `req_ready` is high. The walk then issues up to three entry reads, one after another. Each read waits for its data before the next level is indexed. The block finishes with a one-cycle response that carries one of three outcomes: an ECC address with its protection code, a "no protection" indication, or a fault. Only one walk is in flight at any time.

Top module: `ecc_xlat`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first entry read goes to address `{tbl_base, paddr[38:30], 3'b000}`. `tbl_base` is sampled when the request is accepted. Entries are 8 bytes and 8-byte aligned.
- R3: A valid non-leaf entry carries the next table's page number in bits [38:12]. The second read uses index `paddr[29:21]`, the third uses `paddr[20:12]`, and each is formed the same way as the first. The protection bits of non-leaf entries have no effect.
- R4: Entry bit 0 is the valid flag. An entry with bit 0 clear, at any level, ends the walk with `rsp_status` = 2 (fault), `rsp_prot` = 0 and `rsp_eaddr` = 0. No further entry is read.
- R5: Entry bits [11:3] and [63:39] are reserved. An entry at any level with any of these bits set is treated as a fault, exactly as in R4.
- R6: The leaf entry's bits [2:1] hold the protection code. Code 0 means no protection and gives `rsp_status` = 1, `rsp_eaddr` = 0 and `rsp_prot` = 0.
- R7: Codes 1, 2 and 3 give 2, 4 and 8 tier-2 bytes for each 64-byte line. For these codes the response is `rsp_status` = 0, `rsp_prot` = code, and `rsp_eaddr` = `{leaf bits [38:12], paddr[11:0] >> (6 - code)}`.
- R8: One walk at a time. `req_ready` falls in the cycle after a request is accepted and stays low until the response has been given. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen. A level advances only on `mem_rsp_valid`.
- R9: `rsp_valid` is high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | 27 | Page number of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_paddr | input | 39 | Physical data byte address |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 39 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 no protection, 2 fault |
| rsp_prot | output | 2 | Page protection code (0 unless ok) |
| rsp_eaddr | output | 39 | ECC byte address |

## Verification
The bench tests each protection code with an all-ones page offset. A shift off by one level would then show up as a doubled or halved low field, and a dropped top bit as a truncated one. Faults are placed at each of the three levels, and reserved-bit faults are injected as well. These expose a walk that keeps reading after a bad entry, or that faults on the wrong level. In non-leaf entries the protection bits are randomised, so a design that reads them from the wrong level returns the wrong code. The memory is randomly late both in accepting reads and in returning data. A walk that did not wait would then use stale entry data or repeat reads, and that shows up in the logged read address sequence.

// File: rtl/ecc_xlat_pkg.sv
package ecc_xlat_pkg;

    localparam int unsigned ENTRY_W  = 64;
    localparam int unsigned ENTRY_LG = 3;   // 8-byte entries

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } walk_st_e;

    typedef enum logic [1:0] {
        RS_OK     = 2'd0,
        RS_NOPROT = 2'd1,
        RS_FAULT  = 2'd2
    } rsp_st_e;

endpackage

// File: rtl/ecc_tbl_addr.sv
module ecc_tbl_addr
    import ecc_xlat_pkg::*;
#(
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned LEVELS = 3,
    localparam int unsigned PA_W  = OFF_W + LEVELS * IDX_W,
    localparam int unsigned PFN_W = PA_W - OFF_W,
    localparam int unsigned LVL_W = $clog2(LEVELS)
) (
    input  logic [PFN_W-1:0] ptr,
    input  logic [PA_W-1:0]  paddr,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  addr
);

    logic [IDX_W-1:0] idx_arr [LEVELS];
    logic [IDX_W-1:0] idx;

    // level 0 takes the most significant index field
    for (genvar l = 0; l < LEVELS; l++) begin : g_idx
        assign idx_arr[l] = paddr[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (lvl == LVL_W'(l)) idx = idx_arr[l];
        end
    end

    assign addr = {ptr, OFF_W'({idx, {ENTRY_LG{1'b0}}})};

endmodule

// File: rtl/ecc_entry_dec.sv
module ecc_entry_dec
    import ecc_xlat_pkg::*;
#(
    parameter int unsigned OFF_W = 12,
    parameter int unsigned PFN_W = 27
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               ok,
    output logic [1:0]         prot,
    output logic [PFN_W-1:0]   pfn
);

    localparam int unsigned HI_LO = OFF_W + PFN_W;

    logic rsvd_lo_set;
    logic rsvd_hi_set;

    assign rsvd_lo_set = |entry[OFF_W-1:3];
    assign rsvd_hi_set = |entry[ENTRY_W-1:HI_LO];

    assign ok   = entry[0] && !rsvd_lo_set && !rsvd_hi_set;
    assign prot = entry[2:1];
    assign pfn  = entry[HI_LO-1:OFF_W];

endmodule

// File: rtl/ecc_off_scale.sv
module ecc_off_scale #(
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned LINE_LG = 6,
    parameter int unsigned NCODE   = 4
) (
    input  logic [OFF_W-1:0]         off,
    input  logic [$clog2(NCODE)-1:0] code,
    output logic [OFF_W-1:0]         scaled
);

    localparam int unsigned CODE_W = $clog2(NCODE);

    logic [OFF_W-1:0] cand [NCODE];

    // code c stores 2^c tier-2 bytes per 2^LINE_LG data bytes
    for (genvar c = 0; c < NCODE; c++) begin : g_cand
        if (c == 0) begin : g_none
            assign cand[c] = '0;
        end else begin : g_shift
            assign cand[c] = off >> (LINE_LG - c);
        end
    end

    always_comb begin
        scaled = '0;
        for (int c = 0; c < NCODE; c++) begin
            if (code == CODE_W'(c)) scaled = cand[c];
        end
    end

endmodule

// File: rtl/ecc_xlat.sv
module ecc_xlat
    import ecc_xlat_pkg::*;
#(
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned IDX_W   = 9,
    parameter int unsigned LEVELS  = 3,
    parameter int unsigned LINE_LG = 6,
    localparam int unsigned PA_W   = OFF_W + LEVELS * IDX_W,
    localparam int unsigned PFN_W  = PA_W - OFF_W,
    localparam int unsigned LVL_W  = $clog2(LEVELS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PFN_W-1:0]   tbl_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PA_W-1:0]    req_paddr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [1:0]         rsp_prot,
    output logic [PA_W-1:0]    rsp_eaddr
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        walk_st_e         st;
        logic [LVL_W-1:0] lvl;
        logic [PA_W-1:0]  pa;
        logic [PFN_W-1:0] ptr;
        logic [1:0]       status;
        logic [1:0]       prot;
        logic [PA_W-1:0]  ea;
    } walk_s;

    walk_s q, d;

    logic             ent_ok;
    logic [1:0]       ent_prot;
    logic [PFN_W-1:0] ent_pfn;
    logic [OFF_W-1:0] off_scaled;

    ecc_tbl_addr #(
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .LEVELS (LEVELS)
    ) u_addr (
        .ptr   (q.ptr),
        .paddr (q.pa),
        .lvl   (q.lvl),
        .addr  (mem_req_addr)
    );

    ecc_entry_dec #(
        .OFF_W (OFF_W),
        .PFN_W (PFN_W)
    ) u_dec (
        .entry (mem_rsp_data),
        .ok    (ent_ok),
        .prot  (ent_prot),
        .pfn   (ent_pfn)
    );

    ecc_off_scale #(
        .OFF_W   (OFF_W),
        .LINE_LG (LINE_LG),
        .NCODE   (4)
    ) u_scale (
        .off    (q.pa[OFF_W-1:0]),
        .code   (ent_prot),
        .scaled (off_scaled)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_REQ;
                    d.lvl    = '0;
                    d.pa     = req_paddr;
                    d.ptr    = tbl_base;
                    d.status = RS_OK;
                    d.prot   = '0;
                    d.ea     = '0;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_ok) begin
                        d.st     = ST_DONE;
                        d.status = RS_FAULT;
                        d.prot   = '0;
                        d.ea     = '0;
                    end else if (q.lvl != LAST_LVL) begin
                        d.st  = ST_REQ;
                        d.lvl = q.lvl + 1'b1;
                        d.ptr = ent_pfn;
                    end else if (ent_prot == 2'd0) begin
                        d.st     = ST_DONE;
                        d.status = RS_NOPROT;
                        d.prot   = '0;
                        d.ea     = '0;
                    end else begin
                        d.st     = ST_DONE;
                        d.status = RS_OK;
                        d.prot   = ent_prot;
                        d.ea     = {ent_pfn, off_scaled};
                    end
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_REQ);
    assign rsp_valid     = (q.st == ST_DONE);
    assign rsp_status    = q.status;
    assign rsp_prot      = q.prot;
    assign rsp_eaddr     = q.ea;

endmodule

// File: rtl/ecc_xlat_chk.sv
module ecc_xlat_chk #(
    parameter int unsigned PA_W = 39
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            rsp_valid,
    input logic [1:0]      rsp_status,
    input logic [1:0]      rsp_prot,
    input logic [PA_W-1:0] rsp_eaddr
);

    p_rst_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_req_valid));

    p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    p_status_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));

    p_fault_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2) |-> (rsp_prot == 2'd0 && rsp_eaddr == '0));

    p_noprot_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1) |-> (rsp_eaddr == '0 && rsp_prot == 2'd0));

    p_ok_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0) |-> (rsp_prot != 2'd0));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_memreq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_rsp_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(mem_rsp_valid));

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind ecc_xlat ecc_xlat_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_prot      (rsp_prot),
    .rsp_eaddr     (rsp_eaddr)
);

// File: tb/tb_ecc_xlat.sv
module tb_ecc_xlat;

    localparam int PA_W  = 39;
    localparam int PFN_W = 27;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PFN_W-1:0] tbl_base = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [PA_W-1:0]  req_paddr = '0;
    logic             mem_req_valid;
    logic             mem_req_ready = 1'b0;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_rsp_valid = 1'b0;
    logic [63:0]      mem_rsp_data = '0;
    logic             rsp_valid;
    logic [1:0]       rsp_status;
    logic [1:0]       rsp_prot;
    logic [PA_W-1:0]  rsp_eaddr;

    always #5 clk = ~clk;

    ecc_xlat dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tbl_base      (tbl_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_paddr     (req_paddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_status    (rsp_status),
        .rsp_prot      (rsp_prot),
        .rsp_eaddr     (rsp_eaddr)
    );

    int errs = 0;
    int checks = 0;

    logic [63:0]     mem [logic [PA_W-1:0]];
    logic [PA_W-1:0] rd_log [$];

    // expected results from the bench model
    logic [1:0]      e_st, e_pr;
    logic [PA_W-1:0] e_ea;
    int              e_n;
    logic [PA_W-1:0] e_ad [3];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [8:0] idx_of(input logic [PA_W-1:0] pa, input int l);
        return pa[38 - 9*l -: 9];
    endfunction

    // walk model built from R2..R7
    task automatic model(input logic [PA_W-1:0] pa, input logic [PFN_W-1:0] base);
        logic [PFN_W-1:0] ptr;
        logic [63:0] e;
        logic [11:0] off;
        ptr = base; e_n = 0; e_st = 2'd2; e_pr = 0; e_ea = 0;
        for (int l = 0; l < 3; l++) begin
            e_ad[l] = {ptr, idx_of(pa, l), 3'b000};
            e = rd(e_ad[l]);
            e_n++;
            if (!e[0] || e[11:3] != 0 || e[63:39] != 0) begin
                e_st = 2'd2; return;
            end
            if (l < 2) ptr = e[38:12];
            else if (e[2:1] == 0) begin
                e_st = 2'd1;
            end else begin
                e_st = 2'd0; e_pr = e[2:1];
                off = pa[11:0] >> (6 - int'(e[2:1]));
                e_ea = {e[38:12], off};
            end
        end
    endtask

    // memory responder: random accept delay and random data latency
    initial begin
        int mstate = 0;
        int dly = 0;
        logic [PA_W-1:0] maddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (mstate == 0) begin
                if (mem_req_valid && ($urandom_range(0, 2) != 0)) begin
                    mem_req_ready = 1'b1;
                    maddr = mem_req_addr;
                    rd_log.push_back(mem_req_addr);
                    dly = $urandom_range(0, 2);
                    mstate = 1;
                end
            end else begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = rd(maddr);
                    mstate = 0;
                end else begin
                    dly--;
                end
            end
        end
    end

    task automatic run_txn(input logic [PA_W-1:0] pa, input logic [PFN_W-1:0] base,
                           input int flt, input int rsv, input logic [1:0] pr);
        logic [PFN_W-1:0] p [4];
        logic [63:0] e;
        int t;
        p[0] = base;
        for (int i = 1; i < 4; i++) p[i] = PFN_W'($urandom());
        mem.delete();
        rd_log.delete();
        for (int l = 0; l < 3; l++) begin
            e = {25'd0, p[l+1], 9'd0, (l == 2) ? pr : 2'($urandom()), 1'b1};
            if (l == flt) e[0] = 1'b0;
            if (l == rsv) begin
                if ($urandom_range(0, 1) == 0) e[5] = 1'b1; else e[50] = 1'b1;
            end
            mem[{p[l], idx_of(pa, l), 3'b000}] = e;
        end
        model(pa, base);

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        tbl_base = base;
        req_paddr = pa;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        tbl_base = PFN_W'($urandom());   // R2: sampled only at acceptance
        chk(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);

        t = 0;
        while (!rsp_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk(rsp_valid == 1'b1, "R9 response seen", rsp_valid, 1);
        chk(rsp_status == e_st, "R4/R5/R6/R7 status", rsp_status, e_st);
        chk(rsp_prot == e_pr, "R7 prot code", rsp_prot, e_pr);
        chk(rsp_eaddr == e_ea, "R7 ecc address", rsp_eaddr, e_ea);
        chk(rd_log.size() == e_n, "R4 read count", rd_log.size(), e_n);
        for (int i = 0; i < e_n && i < rd_log.size(); i++) begin
            chk(rd_log[i] == e_ad[i], (i == 0) ? "R2 first entry addr" : "R3 next entry addr",
                rd_log[i], e_ad[i]);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 single cycle", rsp_valid, 0);
        chk(req_ready == 1'b1, "R8 ready after response", req_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [PA_W-1:0] pa;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R1 idle out of reset", req_ready, 1);

        // R7: each code with an all-ones page offset
        for (int c = 1; c < 4; c++) begin
            pa = {27'($urandom()), 12'hFFF};
            run_txn(pa, 27'($urandom()), -1, -1, 2'(c));
        end
        run_txn({27'($urandom()), 12'h040}, 27'($urandom()), -1, -1, 2'd1);
        // R6: no protection
        run_txn(39'($urandom()), 27'($urandom()), -1, -1, 2'd0);
        // R4: invalid at each level
        for (int l = 0; l < 3; l++) run_txn(39'($urandom()), 27'($urandom()), l, -1, 2'd2);
        // R5: reserved bits at each level
        for (int l = 0; l < 3; l++) run_txn(39'($urandom()), 27'($urandom()), -1, l, 2'd3);

        // random mix
        for (int n = 0; n < 60; n++) begin
            int flt = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 2)) : -1;
            int rsv = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 2)) : -1;
            pa = {$urandom(), $urandom()};
            run_txn(pa, 27'($urandom()), flt, rsv, 2'($urandom()));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule